// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block collects two interrupt causes for a small processor core: a timer overflow pulse and a falling edge on an external interrupt pin. Each cause sets a request flag in a status register. The flag latches whether or not the cause is masked and whether or not interrupts are globally enabled. Software can read the status register and can clear flags in it. It cannot set them. A read returns only the flags whose mask bit is set.

A global enable bit is turned on by the enable and return-from-interrupt commands. It is turned off by the disable command and by the controller itself when it takes an interrupt. When the global enable is on and any unmasked flag is pending, the block sends a one-cycle vector request carrying the fixed hardware vector address to the program counter unit. It drops the global enable in the same cycle, so a second request cannot follow until software re-enables.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After a synchronous reset, the status readback, the mask register, the global enable and the vector request are all 0.
- R2: A one-cycle pulse on `tmr_ovf` sets status bit 0 at that clock edge. This holds even while mask bit 0 is 0 and the global enable is 0. A flag stays set until software clears it.
- R3: The interrupt pin passes through two synchronizer flops. A high-to-low change of `ext_pin` sets status bit 3 at the third rising clock edge after the change. A low-to-high change sets no flag.
- R4: A status write keeps each flag whose `wr_data` bit is 1 and clears each flag whose bit is 0. A write never sets a flag. An event arriving in the same cycle as a clearing write leaves its flag set.
- R5: `stat_rd_data` equals the flags ANDed with the mask. Bits other than 0 (timer) and 3 (external) always read 0.
- R6: A mask write stores `wr_data` bits 0 and 3 into `mask_q`. The other bits of `mask_q` stay 0. Bit 0 gates the timer flag and bit 3 gates the external flag.
- R7: `cmd_en` or `cmd_ret` sets `gie` at the next edge and `cmd_dis` clears it. When `cmd_dis` arrives together with `cmd_en` or `cmd_ret`, `cmd_dis` wins.
- R8: When `gie` is 1 and an unmasked flag is pending at an edge, `vec_req` is 1 for exactly the following cycle. At the same edge `gie` drops to 0. `vec_addr` is 0x001.
- R9: No vector request is made while `gie` is 0 or while every pending flag is masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle |
| ext_pin | input | 1 | Asynchronous external interrupt pin, active on falling edge |
| stat_wr | input | 1 | Status register write strobe (clear-only) |
| mask_wr | input | 1 | Mask register write strobe |
| wr_data | input | 8 | Write data for both registers |
| cmd_en | input | 1 | Enable-interrupts command pulse |
| cmd_dis | input | 1 | Disable-interrupts command pulse |
| cmd_ret | input | 1 | Return-from-interrupt command pulse |
| stat_rd_data | output | 8 | Status readback: flags AND mask |
| mask_q | output | 8 | Mask register contents |
| gie | output | 1 | Global interrupt enable |
| vec_req | output | 1 | One-cycle vector request to the PC unit |
| vec_addr | output | 12 | Vector address for the request |

## Verification
Timer events, status writes and mask writes show up at the port at the first rising edge after they are driven. A falling edge on the pin reaches the status readback at the third edge. The vector request follows one edge after the global enable and an unmasked flag are both present at an edge. The bench drives every input at the falling clock edge. Its cycle model advances once per rising edge, using the inputs that were stable at that edge, and it keeps a three-deep copy of the pin history so the external flag is expected on the right edge. Every output is compared at the next falling edge, so each result is checked in the exact cycle it becomes due.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_REG_W     = 8;
  localparam int unsigned IRQ_TMR_IDX   = 0;
  localparam int unsigned IRQ_EXT_IDX   = 3;
  localparam int unsigned IRQ_PC_W      = 12;
  localparam int unsigned IRQ_SYNC_LEN  = 2;
  localparam logic [IRQ_PC_W-1:0] IRQ_HW_VECTOR = 12'h001;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  localparam int unsigned LAST = STAGES - 1;

  // sh[0..LAST] synchronizer, sh[STAGES] previous synchronized value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign fall = sh[STAGES] & ~sh[LAST];

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W       = 8,
  parameter int unsigned TMR_IDX = 0,
  parameter int unsigned EXT_IDX = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tmr_evt,
  input  logic         ext_evt,
  input  logic         stat_wr,
  input  logic         mask_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] flags,
  output logic [W-1:0] mask
);
  localparam logic [W-1:0] IMPL = (W'(1) << TMR_IDX) | (W'(1) << EXT_IDX);

  logic [W-1:0] evt;
  logic [W-1:0] keep;

  always_comb begin
    evt          = '0;
    evt[TMR_IDX] = tmr_evt;
    evt[EXT_IDX] = ext_evt;
    keep         = stat_wr ? wr_data : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= ((flags & keep) | evt) & IMPL;
      if (mask_wr) mask <= wr_data & IMPL;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (IMPL[i]) begin : g_impl
      // R4
      flag_set_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flags[i]) && flags[i]) |-> $past(evt[i]));
      // R2
      flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flags[i]) && !$past(stat_wr)) |-> flags[i]);
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned       PC_W   = 12,
  parameter logic [PC_W-1:0]   VECTOR = 12'h001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pending,
  input  logic            cmd_en,
  input  logic            cmd_dis,
  input  logic            cmd_ret,
  output logic            gie,
  output logic            vec_req,
  output logic [PC_W-1:0] vec_addr
);
  logic take;

  assign take     = gie & pending;
  assign vec_addr = VECTOR;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie     <= 1'b0;
      vec_req <= 1'b0;
    end else begin
      vec_req <= take;
      if (take || cmd_dis)        gie <= 1'b0;
      else if (cmd_en || cmd_ret) gie <= 1'b1;
    end
  end

  // R8
  vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> !vec_req);
  // R8
  vec_gie_drop_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> !gie);
  // R9
  vec_cause_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> ($past(gie) && $past(pending)));
  // R7
  gie_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gie) |-> ($past(cmd_en || cmd_ret) && !$past(cmd_dis)));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned       REG_W     = IRQ_REG_W,
  parameter int unsigned       TMR_IDX   = IRQ_TMR_IDX,
  parameter int unsigned       EXT_IDX   = IRQ_EXT_IDX,
  parameter int unsigned       SYNC_LEN  = IRQ_SYNC_LEN,
  parameter int unsigned       PC_W      = IRQ_PC_W,
  parameter logic [PC_W-1:0]   HW_VECTOR = IRQ_HW_VECTOR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_ovf,
  input  logic             ext_pin,
  input  logic             stat_wr,
  input  logic             mask_wr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             cmd_ret,
  output logic [REG_W-1:0] stat_rd_data,
  output logic [REG_W-1:0] mask_q,
  output logic             gie,
  output logic             vec_req,
  output logic [PC_W-1:0]  vec_addr
);
  logic             ext_fall;
  logic [REG_W-1:0] flags;
  logic [REG_W-1:0] armed;

  irq_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .fall (ext_fall)
  );

  irq_flag_bank #(.W(REG_W), .TMR_IDX(TMR_IDX), .EXT_IDX(EXT_IDX)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .tmr_evt (tmr_ovf),
    .ext_evt (ext_fall),
    .stat_wr (stat_wr),
    .mask_wr (mask_wr),
    .wr_data (wr_data),
    .flags   (flags),
    .mask    (mask_q)
  );

  assign armed        = flags & mask_q;
  assign stat_rd_data = armed;

  irq_gate #(.PC_W(PC_W), .VECTOR(HW_VECTOR)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .pending  (|armed),
    .cmd_en   (cmd_en),
    .cmd_dis  (cmd_dis),
    .cmd_ret  (cmd_ret),
    .gie      (gie),
    .vec_req  (vec_req),
    .vec_addr (vec_addr)
  );
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tmr_ovf = 1'b0, ext_pin = 1'b1, stat_wr = 1'b0, mask_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_en = 1'b0, cmd_dis = 1'b0, cmd_ret = 1'b0;
  logic [7:0] stat_rd_data, mask_q;
  logic       gie, vec_req;
  logic [11:0] vec_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference state
  logic [7:0] m_flag, m_mask;
  logic       m_gie, m_vreq;
  logic [2:0] m_pin;   // [0] first flop, [2] previous synchronized

  always #4 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst(rst), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
    .stat_wr(stat_wr), .mask_wr(mask_wr), .wr_data(wr_data),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_ret(cmd_ret),
    .stat_rd_data(stat_rd_data), .mask_q(mask_q), .gie(gie),
    .vec_req(vec_req), .vec_addr(vec_addr)
  );

  function automatic logic [7:0] keep_mask(input logic wr, input logic [7:0] d);
    return wr ? d : 8'hFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic       fall, take;
    logic [7:0] evt;
    if (rst) begin
      m_flag = 0; m_mask = 0; m_gie = 0; m_vreq = 0; m_pin = 3'b111;
    end else begin
      fall   = m_pin[2] & ~m_pin[1];
      evt    = {4'b0, fall, 2'b0, tmr_ovf};
      take   = m_gie & |(m_flag & m_mask);
      m_flag = ((m_flag & keep_mask(stat_wr, wr_data)) | evt) & 8'h09;
      if (mask_wr) m_mask = wr_data & 8'h09;
      m_vreq = take;
      if (take || cmd_dis)        m_gie = 0;
      else if (cmd_en || cmd_ret) m_gie = 1;
      m_pin  = {m_pin[1:0], ext_pin};
    end
  endtask

  task automatic compare_all();
    check("R5 stat_rd_data", stat_rd_data, m_flag & m_mask);
    check("R6 mask_q", mask_q, m_mask);
    check("R7 gie", gie, m_gie);
    check("R8 vec_req", vec_req, m_vreq);
  endtask

  task automatic idle_inputs();
    tmr_ovf = 0; stat_wr = 0; mask_wr = 0; cmd_en = 0; cmd_dis = 0; cmd_ret = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    rst = 1;
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    check("R1 stat", stat_rd_data, 8'h00);
    check("R1 mask", mask_q, 8'h00);
    check("R1 gie", gie, 1'b0);
    check("R1 vec", vec_req, 1'b0);

    // R2 timer flag latches while masked and disabled
    tmr_ovf = 1; tick();
    check("R2 masked read", stat_rd_data, 8'h00);
    mask_wr = 1; wr_data = 8'hFF; tick();
    check("R6 mask stores bits 0,3", mask_q, 8'h09);
    check("R2 flag latched", stat_rd_data, 8'h01);
    // R9 no request while gie is off
    repeat (3) begin tick(); check("R9 gie off", vec_req, 1'b0); end

    // R4 writing ones does not set, zeros clear
    stat_wr = 1; wr_data = 8'hFF; tick();
    check("R4 write ones", stat_rd_data, 8'h01);
    stat_wr = 1; wr_data = 8'h00; tick();
    check("R4 write zeros", stat_rd_data, 8'h00);

    // R3 falling edge: flag on the third edge
    ext_pin = 0;
    tick(); check("R3 edge1", stat_rd_data, 8'h00);
    tick(); check("R3 edge2", stat_rd_data, 8'h00);
    tick(); check("R3 edge3", stat_rd_data, 8'h08);
    stat_wr = 1; wr_data = 8'h00; tick();
    ext_pin = 1;
    repeat (4) tick();
    check("R3 rising ignored", stat_rd_data, 8'h00);

    // R4 event wins over same-cycle clear
    tmr_ovf = 1; stat_wr = 1; wr_data = 8'h00; tick();
    check("R4 event wins", stat_rd_data, 8'h01);

    // R9 masked pending gives no request
    mask_wr = 1; wr_data = 8'h08; tick();
    cmd_en = 1; tick();
    check("R7 enable", gie, 1'b1);
    tick(); check("R9 masked", vec_req, 1'b0);
    check("R9 gie kept", gie, 1'b1);

    // R8 unmask -> request next edge after pending visible
    mask_wr = 1; wr_data = 8'h01; tick();
    tick();
    check("R8 request", vec_req, 1'b1);
    check("R8 gie dropped", gie, 1'b0);
    check("R8 vector", vec_addr, 12'h001);
    tick(); check("R8 single pulse", vec_req, 1'b0);

    // R7 priority and return
    stat_wr = 1; wr_data = 8'h00; tick();
    cmd_en = 1; cmd_dis = 1; tick();
    check("R7 dis wins", gie, 1'b0);
    cmd_ret = 1; tick();
    check("R7 ret sets", gie, 1'b1);
    cmd_dis = 1; tick();
    check("R7 dis clears", gie, 1'b0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      tmr_ovf = ($urandom % 16) == 0;
      if (($urandom % 6) == 0) ext_pin = ~ext_pin;
      stat_wr = ($urandom % 12) == 0;
      mask_wr = ($urandom % 20) == 0;
      wr_data = 8'($urandom);
      cmd_en  = ($urandom % 15) == 0;
      cmd_dis = ($urandom % 25) == 0;
      cmd_ret = ($urandom % 30) == 0;
      @(posedge clk);
      #1 model_step();
      @(negedge clk);
      compare_all();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule